// File: doc/BRIEF.md
# Inset-Picture Window Overlay Generator

This block draws a small inset picture on top of a main raster. The main-raster pixel and line counters arrive every pixel clock. From them and a small set of controls (coarse position, a fine horizontal delay, a size bit, a border colour code, a fill code, an enable and a blank bit) it decides, pixel by pixel, whether the inset window covers the current position. While it does, it produces 6-bit luma and 6-bit signed-offset chroma samples for the output converters and raises a keying signal for the downstream video switch.

Picture data comes from a field memory as a byte stream. Each byte holds one 6-bit luma sample in its low bits. Two spare bits per byte carry one slice of a chroma sample, so six consecutive bytes yield six luma samples plus one U and one V sample (a 6:1:1 format). The block asks for bytes with a read strobe running six pixels ahead of the picture area. It holds the luma in a short delay line and assembles each group's chroma before that group is displayed.

Outside the window the block emits black luma with mid-scale chroma, so the clamps downstream sample correct levels. A window placed so that it would cover the horizontal or vertical sync interval is turned off entirely.

Top module: `pip_overlay`

## Requirements
- R1: While rst_n is low, y_out is 0, u_out and v_out are 32 and pip_sel is 0.
- R2: The window's top-left pixel is at column X_ORG + x_pos*H_STEP + sw_dly on line Y_ORG + y_pos*V_STEP. Outputs are registered: the result for the counters presented in clock n appears after edge n.
- R3: sw_dly (0 to 15) moves the whole window, border included, right by that many pixels.
- R4: size_sel = 0 gives a picture of W_SMALL pixels by L_SMALL lines; size_sel = 1 gives W_LARGE by L_LARGE. The window adds BRD_W pixels on the left and right and BRD_L lines above and below the picture.
- R5: Picture column i shows bits 5:0 of the byte read for column i as luma. Bytes are taken in groups of six from the first picture column: b0..b5. V = {b2[7:6], b1[7:6], b0[7:6]} and U = {b5[7:6], b4[7:6], b3[7:6]}, and all six columns of the group share them.
- R6: At every position outside the window the outputs are y_out = 0, u_out = v_out = 32 and pip_sel = 0.
- R7: If the window start column is below H_SYNC, its end passes H_TOTAL, its start line is below V_SYNC or its end passes V_TOTAL, no window is shown and no bytes are requested.
- R8: In the border ring, border_code selects {Y,U,V}: 000 = {0,32,32}, 001 = {48,32,32}, 100 = {10,58,26}, 101 = {36,12,8}, 110 = {18,22,58}, 111 = {32,32,32}. Codes 010 and 011 are transparent: the ring gives outside levels and pip_sel = 0.
- R9: blank = 1 makes the whole shown window {0,32,32} with pip_sel = 1, overriding fill, border and picture.
- R10: fill_code 01, 10 and 11 replace the whole window, border included, with the 101, 100 and 110 colours of R8 respectively. 00 leaves the normal picture and border.
- R11: mem_rd is high, combinationally with the counters, exactly on picture lines of a shown window at columns from (picture start - 6) for the picture width. The byte on mem_byte in that same cycle belongs to the matching picture column.
- R12: With win_en = 0 no window is shown (outside levels of R6) and mem_rd stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cnt | input | HW | Main-raster pixel counter, 0 at start of horizontal sync |
| v_cnt | input | VW | Main-raster line counter, 0 at start of vertical sync |
| x_pos | input | 6 | Coarse horizontal window position |
| y_pos | input | 6 | Coarse vertical window position |
| sw_dly | input | 4 | Fine right shift of the window in pixels |
| size_sel | input | 1 | 0 small picture, 1 large picture |
| border_code | input | 3 | Border colour code |
| fill_code | input | 2 | Solid fill select, 00 for normal picture |
| win_en | input | 1 | Window enable |
| blank | input | 1 | Force window to black |
| mem_byte | input | 8 | Packed picture byte from field memory |
| mem_rd | output | 1 | Byte request for the current pixel |
| pip_sel | output | 1 | Overlay key for the video switch |
| y_out | output | 6 | Luma sample |
| u_out | output | 6 | U sample, 32 = zero |
| v_out | output | 6 | V sample, 32 = zero |

## Verification
The bench builds the block on a 160-pixel by 30-line raster with sync widths of 12 pixels and 3 lines, origin offsets 8 and 2, steps of 2 pixels and 1 line, and pictures of 12x4 and 18x6. A frame is then 4800 cycles. At these values both ends of the 64-step position range hit the sync clash rule: exact fits at the right edge and at the sync edges sit one step or one delay pixel away from suppression, and each case takes a single frame. The small picture widths also put several chroma groups on every line, so group boundaries and the six-pixel read lead are exercised many times per frame.

// File: rtl/pip_overlay.sv
module pip_overlay #(
  parameter int H_TOTAL = 910,
  parameter int V_TOTAL = 262,
  parameter int H_SYNC  = 68,
  parameter int V_SYNC  = 9,
  parameter int X_ORG   = 40,
  parameter int Y_ORG   = 4,
  parameter int H_STEP  = 12,
  parameter int V_STEP  = 4,
  parameter int W_SMALL = 84,
  parameter int L_SMALL = 52,
  parameter int W_LARGE = 114,
  parameter int L_LARGE = 70,
  parameter int BRD_W   = 4,
  parameter int BRD_L   = 2,
  localparam int HW     = $clog2(H_TOTAL),
  localparam int VW     = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic [5:0]    x_pos,
  input  logic [5:0]    y_pos,
  input  logic [3:0]    sw_dly,
  input  logic          size_sel,
  input  logic [2:0]    border_code,
  input  logic [1:0]    fill_code,
  input  logic          win_en,
  input  logic          blank,
  input  logic [7:0]    mem_byte,
  output logic          mem_rd,
  output logic          pip_sel,
  output logic [5:0]    y_out,
  output logic [5:0]    u_out,
  output logic [5:0]    v_out
);

  localparam int GRP = 6;
  localparam logic [5:0] MID = 6'd32;

  function automatic logic [17:0] swatch(input logic [2:0] c);
    case (c)
      3'b000:  return {6'd0,  MID,    MID};
      3'b001:  return {6'd48, MID,    MID};
      3'b100:  return {6'd10, 6'd58,  6'd26};
      3'b101:  return {6'd36, 6'd12,  6'd8};
      3'b110:  return {6'd18, 6'd22,  6'd58};
      default: return {6'd32, MID,    MID};
    endcase
  endfunction

  int hh, vv;
  int pw, pl, ww, wl, x0, y0, px0, py0, rd0;
  logic clash, shown, in_win, pic_row, in_pic, rd_on;

  assign hh = int'(h_cnt);
  assign vv = int'(v_cnt);

  always_comb begin
    pw  = size_sel ? W_LARGE : W_SMALL;
    pl  = size_sel ? L_LARGE : L_SMALL;
    ww  = pw + 2 * BRD_W;
    wl  = pl + 2 * BRD_L;
    x0  = X_ORG + int'(x_pos) * H_STEP + int'(sw_dly);
    y0  = Y_ORG + int'(y_pos) * V_STEP;
    px0 = x0 + BRD_W;
    py0 = y0 + BRD_L;
    rd0 = px0 - GRP;
    clash   = (x0 < H_SYNC) || (x0 + ww > H_TOTAL) ||
              (y0 < V_SYNC) || (y0 + wl > V_TOTAL);
    shown   = win_en && !clash;
    in_win  = shown && hh >= x0 && hh < x0 + ww && vv >= y0 && vv < y0 + wl;
    pic_row = vv >= py0 && vv < py0 + pl;
    in_pic  = in_win && pic_row && hh >= px0 && hh < px0 + pw;
    rd_on   = shown && pic_row && hh >= rd0 && hh < rd0 + pw;
  end

  assign mem_rd = rd_on;

  logic [2:0] ph_q, ph;
  logic [5:0] vacc;
  logic [3:0] uacc;
  logic [5:0] hold_u, hold_v;
  logic [5:0] ysh [GRP];

  assign ph = (hh == rd0) ? 3'd0 : ph_q;

  logic        nx_sel;
  logic [17:0] nx_pix;

  always_comb begin
    nx_sel = 1'b0;
    nx_pix = {6'd0, MID, MID};
    if (in_win) begin
      nx_sel = 1'b1;
      if (blank)
        nx_pix = {6'd0, MID, MID};
      else if (fill_code != 2'b00)
        nx_pix = swatch(fill_code == 2'b01 ? 3'b101 :
                        fill_code == 2'b10 ? 3'b100 : 3'b110);
      else if (!in_pic) begin
        if (border_code[2:1] == 2'b01) nx_sel = 1'b0;
        else nx_pix = swatch(border_code);
      end else
        nx_pix = {ysh[GRP-1], hold_u, hold_v};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= 3'd0;
      vacc    <= 6'd0;
      uacc    <= 4'd0;
      hold_u  <= MID;
      hold_v  <= MID;
      for (int k = 0; k < GRP; k++) ysh[k] <= 6'd0;
      pip_sel <= 1'b0;
      y_out   <= 6'd0;
      u_out   <= MID;
      v_out   <= MID;
    end else begin
      ysh[0] <= mem_byte[5:0];
      for (int k = 1; k < GRP; k++) ysh[k] <= ysh[k-1];
      if (rd_on) begin
        ph_q <= (ph == 3'd5) ? 3'd0 : ph + 3'd1;
        case (ph)
          3'd0: vacc[1:0] <= mem_byte[7:6];
          3'd1: vacc[3:2] <= mem_byte[7:6];
          3'd2: vacc[5:4] <= mem_byte[7:6];
          3'd3: uacc[1:0] <= mem_byte[7:6];
          3'd4: uacc[3:2] <= mem_byte[7:6];
          default: begin
            hold_v <= vacc;
            hold_u <= {mem_byte[7:6], uacc};
          end
        endcase
      end
      pip_sel <= nx_sel;
      {y_out, u_out, v_out} <= nx_pix;
    end
  end

  p_outside_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pip_sel |-> (y_out == 6'd0 && u_out == MID && v_out == MID));

  p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pip_sel |-> ($past(h_cnt) >= HW'(H_SYNC) && $past(v_cnt) >= VW'(V_SYNC)));

  p_blank_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pip_sel && $past(blank)) |-> (y_out == 6'd0 && u_out == MID && v_out == MID));

  p_fill_green_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pip_sel && $past(!blank && fill_code == 2'b01)) |->
      (y_out == 6'd36 && u_out == 6'd12 && v_out == 6'd8));

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!win_en) |-> !pip_sel);

  p_no_read_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !mem_rd);

endmodule

// File: tb/sim_pip_overlay.sv
module sim_pip_overlay;

  localparam int HT = 160, VT = 30, HS = 12, VS = 3, XO = 8, YO = 2;
  localparam int HST = 2, VST = 1, WS = 12, LS = 4, WL = 18, LL = 6;
  localparam int BW = 4, BL = 2;
  localparam int HW = $clog2(HT), VW = $clog2(VT);
  localparam logic [5:0] MID = 6'd32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] h_cnt = '0;
  logic [VW-1:0] v_cnt = '0;
  logic [5:0] x_pos = '0, y_pos = '0;
  logic [3:0] sw_dly = '0;
  logic size_sel = 1'b0, win_en = 1'b0, blank = 1'b0;
  logic [2:0] border_code = '0;
  logic [1:0] fill_code = '0;
  logic [7:0] mem_byte = '0;
  logic mem_rd, pip_sel;
  logic [5:0] y_out, u_out, v_out;

  always #2 clk = ~clk;

  pip_overlay #(.H_TOTAL(HT), .V_TOTAL(VT), .H_SYNC(HS), .V_SYNC(VS),
    .X_ORG(XO), .Y_ORG(YO), .H_STEP(HST), .V_STEP(VST),
    .W_SMALL(WS), .L_SMALL(LS), .W_LARGE(WL), .L_LARGE(LL),
    .BRD_W(BW), .BRD_L(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .x_pos(x_pos), .y_pos(y_pos), .sw_dly(sw_dly), .size_sel(size_sel),
    .border_code(border_code), .fill_code(fill_code), .win_en(win_en),
    .blank(blank), .mem_byte(mem_byte), .mem_rd(mem_rd), .pip_sel(pip_sel),
    .y_out(y_out), .u_out(u_out), .v_out(v_out));

  typedef struct { logic [18:0] val; int tag; int h; int v; } item_t;
  item_t q[$];
  int chk = 0, bad = 0;
  int sel_cnt, first_h, first_v;
  bit seen;

  function automatic string tname(int t);
    case (t)
      5: return "R5";   6: return "R6";   7: return "R7";
      8: return "R8";   9: return "R9";  10: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [7:0] mb(int h, int v);
    return 8'((h * 37 + v * 53 + (h >> 3) * 11) ^ (v << 2));
  endfunction

  function automatic logic [17:0] col(logic [2:0] c);
    case (c)
      3'b000:  return {6'd0, MID, MID};
      3'b001:  return {6'd48, MID, MID};
      3'b100:  return {6'd10, 6'd58, 6'd26};
      3'b101:  return {6'd36, 6'd12, 6'd8};
      3'b110:  return {6'd18, 6'd22, 6'd58};
      default: return {6'd32, MID, MID};
    endcase
  endfunction

  function automatic int pwid(); return size_sel ? WL : WS; endfunction
  function automatic int plen(); return size_sel ? LL : LS; endfunction
  function automatic int wx0(); return XO + int'(x_pos) * HST + int'(sw_dly); endfunction
  function automatic int wy0(); return YO + int'(y_pos) * VST; endfunction
  function automatic bit vis();
    int ww = pwid() + 2 * BW, wl = plen() + 2 * BL;
    return win_en && !(wx0() < HS || wx0() + ww > HT || wy0() < VS || wy0() + wl > VT);
  endfunction

  function automatic bit rd_exp(int h, int v);
    int px0 = wx0() + BW, py0 = wy0() + BL;
    return vis() && v >= py0 && v < py0 + plen() && h >= px0 - 6 && h < px0 - 6 + pwid();
  endfunction

  function automatic logic [18:0] model(int h, int v, output int tag);
    int ww, wl, x0, y0, px0, py0, i, b;
    logic [7:0] b0, b1, b2, b3, b4, b5, cur;
    ww = pwid() + 2 * BW; wl = plen() + 2 * BL;
    x0 = wx0(); y0 = wy0(); px0 = x0 + BW; py0 = y0 + BL;
    if (!win_en) begin tag = 12; return {1'b0, 6'd0, MID, MID}; end
    if (!vis()) begin tag = 7; return {1'b0, 6'd0, MID, MID}; end
    if (!(h >= x0 && h < x0 + ww && v >= y0 && v < y0 + wl)) begin
      tag = 6; return {1'b0, 6'd0, MID, MID};
    end
    if (blank) begin tag = 9; return {1'b1, 6'd0, MID, MID}; end
    if (fill_code != 2'b00) begin
      tag = 10;
      return {1'b1, col(fill_code == 2'b01 ? 3'b101 : fill_code == 2'b10 ? 3'b100 : 3'b110)};
    end
    if (!(v >= py0 && v < py0 + plen() && h >= px0 && h < px0 + pwid())) begin
      tag = 8;
      if (border_code[2:1] == 2'b01) return {1'b0, 6'd0, MID, MID};
      return {1'b1, col(border_code)};
    end
    tag = 5;
    i = h - px0;
    b = px0 - 6 + 6 * (i / 6);
    cur = mb(px0 - 6 + i, v);
    b0 = mb(b, v); b1 = mb(b + 1, v); b2 = mb(b + 2, v);
    b3 = mb(b + 3, v); b4 = mb(b + 4, v); b5 = mb(b + 5, v);
    return {1'b1, cur[5:0], b5[7:6], b4[7:6], b3[7:6], b2[7:6], b1[7:6], b0[7:6]};
  endfunction

  task automatic check(string req, int act, int exp, string what);
    chk++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) begin
      item_t it;
      logic [18:0] act;
      it = q.pop_front();
      act = {pip_sel, y_out, u_out, v_out};
      chk++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s pixel h=%0d v=%0d: actual=%h expected=%h",
                 tname(it.tag), it.h, it.v, act, it.val);
      end
      if (act[18] === 1'b1) begin
        sel_cnt++;
        if (!seen) begin seen = 1; first_h = it.h; first_v = it.v; end
      end
    end
  end

  task automatic run_frame(bit en, bit bk, bit sz, logic [2:0] bc, logic [1:0] fc,
                           int xp, int yp, int sd, string req);
    int rd_cnt = 0, tg, exp_area, eh, ev;
    bit transp;
    win_en = en; blank = bk; size_sel = sz; border_code = bc; fill_code = fc;
    x_pos = 6'(xp); y_pos = 6'(yp); sw_dly = 4'(sd);
    seen = 0; sel_cnt = 0;
    for (int v = 0; v < VT; v++) begin
      for (int h = 0; h < HT; h++) begin
        logic [18:0] e;
        @(negedge clk);
        h_cnt = HW'(h); v_cnt = VW'(v); mem_byte = mb(h, v);
        e = model(h, v, tg);
        q.push_back('{e, tg, h, v});
        #1;
        chk++;
        if (mem_rd !== rd_exp(h, v)) begin
          bad++;
          $display("FAIL R11 read strobe h=%0d v=%0d: actual=%b expected=%b",
                   h, v, mem_rd, rd_exp(h, v));
        end
        if (mem_rd === 1'b1) rd_cnt++;
      end
    end
    @(negedge clk);
    h_cnt = '0; v_cnt = '0;
    begin logic [18:0] e; e = model(0, 0, tg); q.push_back('{e, tg, 0, 0}); end
    @(posedge clk); #2;
    transp = (bc[2:1] == 2'b01) && fc == 2'b00 && !bk;
    if (!vis()) exp_area = 0;
    else if (transp) exp_area = pwid() * plen();
    else exp_area = (pwid() + 2 * BW) * (plen() + 2 * BL);
    check(req, sel_cnt, exp_area, "keyed pixel count");               // R4, R7, R12
    check("R11", rd_cnt, vis() ? pwid() * plen() : 0, "byte request count");
    if (exp_area > 0) begin
      eh = transp ? wx0() + BW : wx0();
      ev = transp ? wy0() + BL : wy0();
      check(req, first_h, eh, "window start column");                 // R2, R3
      check(req, first_v, ev, "window start line");
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", chk, bad);
    $finish;
  end

  initial begin
    win_en = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1", y_out, 0, "reset luma");
    check("R1", u_out, 32, "reset U");
    check("R1", v_out, 32, "reset V");
    check("R1", pip_sel, 0, "reset key");
    @(negedge clk);
    rst_n = 1'b1;
    run_frame(1, 0, 0, 3'b001, 2'b00, 10, 5, 0, "R2");   // R2 R4 R5 R8 light grey
    run_frame(1, 0, 1, 3'b101, 2'b00, 20, 6, 5, "R3");   // R3 R4 large, green ring
    run_frame(1, 0, 0, 3'b010, 2'b00, 30, 4, 0, "R8");   // transparent 010
    run_frame(1, 0, 0, 3'b011, 2'b00, 12, 3, 9, "R8");   // transparent 011
    run_frame(1, 0, 1, 3'b110, 2'b10, 15, 5, 2, "R10");  // fill blue over red ring
    run_frame(1, 0, 0, 3'b010, 2'b11, 15, 5, 0, "R10");  // fill red covers transparent ring
    run_frame(1, 1, 0, 3'b100, 2'b01, 15, 5, 0, "R9");   // blank beats fill
    run_frame(0, 0, 0, 3'b001, 2'b00, 10, 5, 0, "R12");  // disabled
    run_frame(1, 0, 1, 3'b111, 2'b00, 63, 5, 0, "R7");   // exact fit at right edge
    run_frame(1, 0, 1, 3'b111, 2'b00, 63, 5, 1, "R7");   // one pixel over: suppressed
    run_frame(1, 0, 0, 3'b000, 2'b00, 1, 5, 0, "R7");    // over left sync: suppressed
    run_frame(1, 0, 0, 3'b000, 2'b00, 2, 5, 0, "R7");    // just clear of left sync
    run_frame(1, 0, 1, 3'b100, 2'b00, 10, 0, 0, "R7");   // over vertical sync
    run_frame(1, 0, 1, 3'b100, 2'b00, 10, 18, 0, "R7");  // exact fit at bottom
    run_frame(1, 0, 1, 3'b100, 2'b00, 10, 19, 0, "R7");  // past bottom: suppressed
    $display("test done: total=%0d bad=%0d", chk, bad);
    $finish;
  end

endmodule